// File: doc/BRIEF.md
# Clock Counter Configuration Scan Chain

This block is the configuration side of a clock synthesizer's output counters. A long serial register, clocked by the scan clock, takes new counter settings one bit per edge. Shifting is permitted only while a scan enable is held high, and the first shift happens one edge after the enable is first seen. Each bit that is shifted in pushes the oldest bit out of the serial output. This lets a controller read back the previous settings while it loads new ones.

A single-cycle commit pulse takes a snapshot of the serial register and starts an update. A busy flag goes high for a fixed number of scan-clock cycles. During that time the counters take the snapshot one after another, each in its own slot, which models counters that update on their own clocks. The falling edge of the flag means that every counter now holds its new value. A commit that arrives while the flag is high has no effect. The settings word is also presented decoded: for each counter, a high-phase count, a low-phase count and their sum as the division ratio.

Top module: `clkcfg_scan_chain`

## Requirements
- R1: While the active-low reset input is low, the settings word equals RST_WORD (default: every 16-bit counter field holds 16'h0101), the busy flag is 0 and the serial output is 0, because the serial register is cleared.
- R2: On an edge where the scan enable is sampled low, the serial register keeps its contents whatever the serial data input does.
- R3: After the enable rises, the first edge that samples it high does not shift. Each later edge with the enable still high shifts in one bit at bit 0 and moves every bit one place toward bit 143. Shifting a 144-bit word most significant bit first therefore leaves exactly that word in the register.
- R4: The serial output always shows bit 143 of the serial register, so the previous contents stream out most significant bit first, one bit per shift.
- R5: A commit pulse sampled while the flag is low makes the flag high from the next edge, and the flag stays high for exactly LAT (default 8) scan-clock cycles.
- R6: Counter i occupies settings bits [16*i+15:16*i]. It takes its snapshotted value on edge (i mod LAT)+1 after the commit edge, and keeps its previous value before that edge. When the flag falls, the whole settings word equals the snapshot.
- R7: A commit pulse sampled while the flag is high is ignored: the flag still falls on schedule, and the snapshot already taken is kept.
- R8: For counter i, the high count is settings bits [16*i+15:16*i+8] and the low count is bits [16*i+7:16*i], presented at the same positions 8*i of the high and low outputs. The division output, 9 bits per counter at position 9*i, is their unsigned sum.
- R9: Shifting during an update leaves the snapshot in progress unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk_i | input | 1 | Scan clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| scan_en_i | input | 1 | Scan enable that gates shifting |
| scan_din_i | input | 1 | Serial data in |
| commit_i | input | 1 | One-cycle update pulse |
| scan_dout_o | output | 1 | Serial data out (bit 143 of the serial register) |
| busy_o | output | 1 | High while the counters take new settings |
| cfg_word_o | output | 144 | Active settings word |
| cnt_high_o | output | 72 | High-phase count per counter |
| cnt_low_o | output | 72 | Low-phase count per counter |
| cnt_div_o | output | 81 | Division ratio (high plus low) per counter |

## Verification
The assertions assume that the scan enable, the serial data and the commit input are synchronous to the scan clock. They also assume that commit is a one-cycle pulse. The stimulus meets these conditions by changing every input only on the falling edge, and it raises commit for exactly one cycle. It also raises commit once during an update, on purpose, to exercise the rule that such a pulse is ignored. Reset is the only input driven between clock edges, because it is asynchronous by design.

// File: rtl/clkcfg_pkg.sv
`timescale 1ns/1ps
package clkcfg_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } upd_state_t;

  // commit slot, counted from zero, of a counter within the update window
  function automatic int unsigned slot_of(input int unsigned idx, input int unsigned lat);
    return idx % lat;
  endfunction

endpackage

// File: rtl/clkcfg_rst_sync.sv
`timescale 1ns/1ps
module clkcfg_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/clkcfg_scan_shift.sv
`timescale 1ns/1ps
module clkcfg_scan_shift #(
  parameter int unsigned CHAIN_W = 144
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               din_i,
  output logic [CHAIN_W-1:0] chain_o,
  output logic               dout_o
);

  logic               en_q, en_d;
  logic [CHAIN_W-1:0] chain_q, chain_d;
  logic               shift_go;

  // the registered enable delays the first shift by one edge
  assign shift_go = en_q & en_i;

  always_comb begin
    en_d    = en_i;
    chain_d = chain_q;
    if (shift_go) chain_d = {chain_q[CHAIN_W-2:0], din_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      chain_q <= '0;
    end else begin
      en_q    <= en_d;
      chain_q <= chain_d;
    end
  end

  assign chain_o = chain_q;
  assign dout_o  = chain_q[CHAIN_W-1];

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(chain_o)); // R2
  AST_FIRST_EDGE_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |=> $stable(chain_o)); // R3
  AST_DOUT_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |=> dout_o == $past(chain_o[CHAIN_W-2])); // R4

endmodule

// File: rtl/clkcfg_commit_ctrl.sv
`timescale 1ns/1ps
module clkcfg_commit_ctrl #(
  parameter int unsigned LAT = 8,
  parameter int unsigned ELW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           commit_i,
  output logic           capture_o,
  output logic           busy_o,
  output logic [ELW-1:0] elapsed_o
);

  import clkcfg_pkg::*;

  localparam logic [ELW-1:0] LAST = ELW'(LAT - 1);

  upd_state_t     state_q, state_d;
  logic [ELW-1:0] elapsed_q, elapsed_d;

  always_comb begin
    state_d   = state_q;
    elapsed_d = elapsed_q;
    unique case (state_q)
      ST_IDLE: begin
        if (commit_i) begin
          state_d   = ST_BUSY;
          elapsed_d = '0;
        end
      end
      ST_BUSY: begin
        if (elapsed_q == LAST) begin
          state_d   = ST_IDLE;
          elapsed_d = '0;
        end else begin
          elapsed_d = elapsed_q + 1'b1;
        end
      end
      default: begin
        state_d   = ST_IDLE;
        elapsed_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      elapsed_q <= '0;
    end else begin
      state_q   <= state_d;
      elapsed_q <= elapsed_d;
    end
  end

  assign busy_o    = (state_q == ST_BUSY);
  assign capture_o = (state_q == ST_IDLE) && commit_i;
  assign elapsed_o = elapsed_q;

  AST_BUSY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !busy_o) |=> busy_o); // R5
  AST_BUSY_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(commit_i)); // R5
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && commit_i && elapsed_o != LAST) |=> (busy_o && elapsed_o == $past(elapsed_o) + 1'b1)); // R7

endmodule

// File: rtl/clkcfg_counter_bank.sv
`timescale 1ns/1ps
module clkcfg_counter_bank #(
  parameter int unsigned NUM_CNT = 9,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned LAT     = 8,
  parameter int unsigned ELW     = 4,
  parameter logic [NUM_CNT*CNT_W-1:0] RST_WORD = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     capture_i,
  input  logic [NUM_CNT*CNT_W-1:0] chain_i,
  input  logic                     busy_i,
  input  logic [ELW-1:0]           elapsed_i,
  output logic [NUM_CNT*CNT_W-1:0] word_o
);

  localparam int unsigned WORD_W = NUM_CNT * CNT_W;

  logic [WORD_W-1:0] pend_q, pend_d;

  // snapshot of the serial register taken at the commit edge
  always_comb begin
    pend_d = pend_q;
    if (capture_i) pend_d = chain_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= RST_WORD;
    else         pend_q <= pend_d;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    localparam int unsigned      SLOT_I = clkcfg_pkg::slot_of(g, LAT);
    localparam logic [ELW-1:0]   SLOT   = ELW'(SLOT_I);
    logic             load;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    assign load = busy_i && (elapsed_i == SLOT);

    always_comb begin
      cnt_d = cnt_q;
      if (load) cnt_d = pend_q[g*CNT_W +: CNT_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= RST_WORD[g*CNT_W +: CNT_W];
      else         cnt_q <= cnt_d;
    end

    assign word_o[g*CNT_W +: CNT_W] = cnt_q;
  end

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(word_o)); // R6
  AST_DONE_COMMITTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (word_o == pend_q)); // R6
  AST_SNAPSHOT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(pend_q)); // R9

endmodule

// File: rtl/clkcfg_scan_chain.sv
`timescale 1ns/1ps
module clkcfg_scan_chain #(
  parameter int unsigned NUM_CNT = 9,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned LAT     = 8,
  parameter logic [NUM_CNT*CNT_W-1:0] RST_WORD = {NUM_CNT{16'h0101}}
) (
  input  logic                             scan_clk_i,
  input  logic                             arst_ni,
  input  logic                             scan_en_i,
  input  logic                             scan_din_i,
  input  logic                             commit_i,
  output logic                             scan_dout_o,
  output logic                             busy_o,
  output logic [NUM_CNT*CNT_W-1:0]         cfg_word_o,
  output logic [NUM_CNT*(CNT_W/2)-1:0]     cnt_high_o,
  output logic [NUM_CNT*(CNT_W/2)-1:0]     cnt_low_o,
  output logic [NUM_CNT*(CNT_W/2+1)-1:0]   cnt_div_o
);

  localparam int unsigned CHAIN_W = NUM_CNT * CNT_W;
  localparam int unsigned HALF_W  = CNT_W / 2;
  localparam int unsigned DIV_W   = HALF_W + 1;
  localparam int unsigned ELW     = (LAT < 2) ? 1 : $clog2(LAT);

  logic               rst_n;
  logic [CHAIN_W-1:0] chain;
  logic               capture;
  logic [ELW-1:0]     elapsed;

  clkcfg_rst_sync u_rst_sync (
    .clk_i   (scan_clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_n)
  );

  clkcfg_scan_shift #(.CHAIN_W(CHAIN_W)) u_shift (
    .clk_i   (scan_clk_i),
    .rst_ni  (rst_n),
    .en_i    (scan_en_i),
    .din_i   (scan_din_i),
    .chain_o (chain),
    .dout_o  (scan_dout_o)
  );

  clkcfg_commit_ctrl #(.LAT(LAT), .ELW(ELW)) u_ctrl (
    .clk_i     (scan_clk_i),
    .rst_ni    (rst_n),
    .commit_i  (commit_i),
    .capture_o (capture),
    .busy_o    (busy_o),
    .elapsed_o (elapsed)
  );

  clkcfg_counter_bank #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .LAT     (LAT),
    .ELW     (ELW),
    .RST_WORD(RST_WORD)
  ) u_bank (
    .clk_i     (scan_clk_i),
    .rst_ni    (rst_n),
    .capture_i (capture),
    .chain_i   (chain),
    .busy_i    (busy_o),
    .elapsed_i (elapsed),
    .word_o    (cfg_word_o)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_dec
    logic [HALF_W-1:0] hi, lo;
    assign hi = cfg_word_o[g*CNT_W + HALF_W +: HALF_W];
    assign lo = cfg_word_o[g*CNT_W +: HALF_W];
    assign cnt_high_o[g*HALF_W +: HALF_W] = hi;
    assign cnt_low_o[g*HALF_W +: HALF_W]  = lo;
    assign cnt_div_o[g*DIV_W +: DIV_W]    = {1'b0, hi} + {1'b0, lo};
  end

  AST_RESET_IDLE: assert property (@(posedge scan_clk_i)
    !rst_n |-> (!busy_o && !scan_dout_o)); // R1

endmodule

// File: tb/clkcfg_scan_chain_bench.sv
`timescale 1ns/1ps
module clkcfg_scan_chain_bench;

  localparam int NC  = 9;
  localparam int CW  = 16;
  localparam int W   = NC * CW;
  localparam int LAT = 8;
  localparam logic [W-1:0] RSTW = {NC{16'h0101}};

  localparam logic [W-1:0] VEC [4] = '{
    {16'h0102, 16'h0304, 16'h0506, 16'h0708, 16'h090A, 16'h0B0C, 16'h0D0E, 16'h0F10, 16'h1112},
    {NC{16'hFF01}},
    {NC{16'h5AA5}},
    {16'hFFFF, 16'h0000, 16'hC33C, 16'h8001, 16'h7FFE, 16'h1234, 16'hABCD, 16'h00FF, 16'hFF00}
  };

  logic clk = 1'b0;
  logic arst_n, en, din, commit;
  logic dout, busy;
  logic [W-1:0] cfg;
  logic [NC*8-1:0] hi_o, lo_o;
  logic [NC*9-1:0] div_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  clkcfg_scan_chain u_clkcfg_scan_chain (
    .scan_clk_i  (clk),
    .arst_ni     (arst_n),
    .scan_en_i   (en),
    .scan_din_i  (din),
    .commit_i    (commit),
    .scan_dout_o (dout),
    .busy_o      (busy),
    .cfg_word_o  (cfg),
    .cnt_high_o  (hi_o),
    .cnt_low_o   (lo_o),
    .cnt_div_o   (div_o)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mix(input logic [W-1:0] oldw, input logic [W-1:0] neww, input int k);
    logic [W-1:0] r = oldw;
    for (int i = 0; i < NC; i++)
      if ((i % LAT) < k) r[i*CW +: CW] = neww[i*CW +: CW];
    return r;
  endfunction

  task automatic chk_decode(input logic [W-1:0] w);
    logic [NC*8-1:0] eh, el;
    logic [NC*9-1:0] ed;
    for (int i = 0; i < NC; i++) begin
      eh[i*8 +: 8] = w[i*CW + 8 +: 8];
      el[i*8 +: 8] = w[i*CW +: 8];
      ed[i*9 +: 9] = {1'b0, w[i*CW + 8 +: 8]} + {1'b0, w[i*CW +: 8]};
    end
    chk(hi_o == eh, "R8 high counts", W'(hi_o), W'(eh));
    chk(lo_o == el, "R8 low counts", W'(lo_o), W'(el));
    chk(div_o == ed, "R8 division ratios", W'(div_o), W'(ed));
  endtask

  // shift a word in MSB first while checking that the old contents stream out
  task automatic shift_word(input logic [W-1:0] neww, input logic [W-1:0] oldw);
    int bad = 0;
    logic act_b = 1'b0, exp_b = 1'b0;
    @(negedge clk) en = 1'b1;
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      if (dout !== oldw[W-1-k] && bad == 0) begin
        act_b = dout; exp_b = oldw[W-1-k];
      end
      if (dout !== oldw[W-1-k]) bad++;
      din = neww[W-1-k];
    end
    @(negedge clk) en = 1'b0;
    chk(bad == 0, "R3 R4 serial out streams old contents", W'(act_b), W'(exp_b));
  endtask

  task automatic commit_word(input logic [W-1:0] neww, input logic [W-1:0] oldw);
    @(negedge clk);
    chk(busy == 1'b0, "R5 idle before commit", W'(busy), W'(0));
    commit = 1'b1;
    @(negedge clk) commit = 1'b0;
    chk(busy == 1'b1, "R5 busy after commit", W'(busy), W'(1));
    chk(cfg == oldw, "R6 no counter loaded at commit edge", cfg, oldw);
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      chk(cfg == mix(oldw, neww, k), "R6 staged counter commit", cfg, mix(oldw, neww, k));
      chk(busy == (k < LAT), "R5 busy duration", W'(busy), W'(k < LAT));
    end
    chk(cfg == neww, "R3 full word committed", cfg, neww);
  endtask

  initial begin
    #750000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] prev_chain, prev_cfg;
    logic hold_v;
    arst_n = 1'b0; en = 1'b0; din = 1'b0; commit = 1'b0;
    #12;
    chk(cfg == RSTW, "R1 reset settings word", cfg, RSTW);
    chk(busy == 1'b0, "R1 reset busy", W'(busy), W'(0));
    chk(dout == 1'b0, "R1 reset serial out", W'(dout), W'(0));
    chk_decode(cfg);
    @(negedge clk) arst_n = 1'b1;
    repeat (4) @(negedge clk);

    prev_chain = '0;
    prev_cfg   = RSTW;
    for (int v = 0; v < 4; v++) begin
      shift_word(VEC[v], prev_chain);
      hold_v = dout;
      for (int t = 0; t < 6; t++) begin
        @(negedge clk) din = ~din;
        chk(dout == hold_v, "R2 hold with enable low", W'(dout), W'(hold_v));
      end
      commit_word(VEC[v], prev_cfg);
      chk_decode(cfg);
      prev_chain = VEC[v];
      prev_cfg   = VEC[v];
    end

    // R7 / R9: commit during update ignored, shifting during update harmless
    shift_word(VEC[0], prev_chain);
    @(negedge clk) commit = 1'b1;
    @(negedge clk) begin commit = 1'b0; en = 1'b1; end
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      din    = VEC[1][W-1-k];
      commit = (k == 3);
      chk(busy == (k < LAT), "R7 busy not restarted", W'(busy), W'(k < LAT));
    end
    @(negedge clk) begin en = 1'b0; commit = 1'b0; end
    chk(cfg == VEC[0], "R9 snapshot kept while shifting", cfg, VEC[0]);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R7 late commit ignored", W'(busy), W'(0));
    chk(cfg == VEC[0], "R7 settings unchanged", cfg, VEC[0]);

    // asynchronous reset in mid-operation
    #1 arst_n = 1'b0;
    #1;
    chk(cfg == RSTW, "R1 async reset settings word", cfg, RSTW);
    chk(busy == 1'b0, "R1 async reset busy", W'(busy), W'(0));
    chk(dout == 1'b0, "R1 async reset serial out", W'(dout), W'(0));
    @(negedge clk) arst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule